// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface Model

This block is a synthesizable stand-in for the device side of a parallel NOR flash. A host issues write cycles (address, data, write strobe) and read cycles on a simple synchronous bus. The block decodes the low byte of each write as a command. Single-cycle commands change the read mode or clear errors. Two-cycle commands pair a setup code with a second write that confirms or supplies the operand. The block stores a small word array in flops, a lock state for each block, and an 8-bit status register. Reads return array words, the status register, or identifier and lock data, depending on the current read mode.

The controller is a state machine with six states:
- `ST_IDLE` decodes single-cycle commands. Writing 0x10, 0x20 or 0x60 moves it to `ST_PROG_SETUP`, `ST_ERASE_SETUP` or `ST_LOCK_SETUP`.
- From `ST_PROG_SETUP`, the next write goes to `ST_PROG_BUSY` if accepted, or back to `ST_IDLE` if rejected.
- From `ST_ERASE_SETUP`, a confirm goes to `ST_ERASE_BUSY`. A rejected or malformed second write goes back to `ST_IDLE`.
- `ST_LOCK_SETUP` always returns to `ST_IDLE` after one write.
- The two busy states count down a programmable number of cycles, commit the operation on the last one, and return to `ST_IDLE`.

The input `vpp_ok` stands in for the programming-supply check.

Top module: `nor_cmd_emu`

## Requirements
- R1: After reset the read mode is array, status reads 0x80 (ready, no errors), every array word is all ones, and every block is locked but not locked down.
- R2: Writing 0xFF in idle selects array mode. Reads then return the stored word at the read address.
- R3: Writing 0x90 in idle selects identifier mode. The in-block word offset selects the data: offset 0 returns MFR_CODE, offset 1 returns DEV_CODE, offset 2 returns the lock status of the addressed block, and any other offset returns zero. In the lock status, bit 0 means locked and bit 1 means locked down.
- R4: Writing 0x70 selects status mode. The status register has bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 supply error and bit 1 locked-block error. All other bits read 0.
- R5: Writing 0x50 in idle clears bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R6: After a 0x60 setup, the next write acts on the block containing its address. 0x01 locks the block. 0xD0 unlocks it unless it is locked down. 0x2F locks it and sets lock-down, which only reset removes. Any other code leaves the lock state unchanged.
- R7: 0x10 selects status mode and arms a program. The next write programs the word at that write's address with old AND data.
- R8: 0x20 followed by 0xD0 erases the block containing the confirm address: every word of that block becomes all ones, and other blocks are untouched.
- R9: After a 0x20 setup, a second write other than 0xD0 sets bits 5 and 4 and erases nothing.
- R10: A program or erase aimed at a locked block sets bit 1 together with bit 4 (program) or bit 5 (erase) and leaves the array unchanged.
- R11: A program or erase whose second write sees `vpp_ok` low sets bit 3 together with bit 4 or bit 5 and leaves the array unchanged.
- R12: An accepted program keeps status bit 7 at 0 for exactly PROG_CYCLES reads issued on consecutive cycles after the operand write; an erase does the same for ERASE_CYCLES after the confirm write. During that time every write except 0x70 is ignored.
- R13: `rdata` is updated at the clock edge where `rd_en` is high, from the mode and state before that edge, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; low byte is the command code |
| vpp_ok | input | 1 | Programming supply in range |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with 16-bit words, 8-word blocks and four blocks, so that identifier offsets, block-boundary erase and lock-down can all be reached within a few addresses. It sets PROG_CYCLES to 3 and ERASE_CYCLES to 6. These short windows let the bench poll status every cycle and count the exact busy length, including the case where an ignored 0xFF write lands inside an erase. The bench reaches every error path: locked target, supply low, and a bad erase confirm.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_SETUP,
        ST_ERASE_SETUP,
        ST_LOCK_SETUP,
        ST_PROG_BUSY,
        ST_ERASE_BUSY
    } ctl_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT
    } rd_mode_e;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_SET,
        LK_CLEAR,
        LK_FREEZE
    } lock_op_e;

    // command codes (low byte of write data)
    localparam logic [7:0] OP_ARRAY     = 8'hFF;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_CLEAR     = 8'h50;
    localparam logic [7:0] OP_PROG      = 8'h10;
    localparam logic [7:0] OP_ERASE     = 8'h20;
    localparam logic [7:0] OP_LOCK      = 8'h60;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_LK_SET    = 8'h01;
    localparam logic [7:0] OP_LK_FREEZE = 8'h2F;

    // status bit positions
    localparam int SB_READY  = 7;
    localparam int SB_ERASE  = 5;
    localparam int SB_PROG   = 4;
    localparam int SB_SUPPLY = 3;
    localparam int SB_LOCKED = 1;

endpackage

// File: rtl/nor_cmd_ctl.sv
module nor_cmd_ctl
    import nor_emu_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vpp_ok,
    input  logic              tgt_locked,
    output rd_mode_e          rd_mode,
    output logic [7:0]        status,
    output lock_op_e          lock_op,
    output logic              prog_commit,
    output logic              erase_commit,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    ctl_state_e       state, state_nxt;
    rd_mode_e         mode_nxt;
    logic [7:0]       err_q, err_set;
    logic             err_clr;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_q, cnt_init;
    logic             busy;
    logic [7:0]       cmd;

    assign cmd  = wdata[7:0];
    assign busy = (state == ST_PROG_BUSY) || (state == ST_ERASE_BUSY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and decode decisions
    always_comb begin
        state_nxt = state;
        mode_nxt  = rd_mode;
        err_set   = '0;
        err_clr   = 1'b0;
        cnt_load  = 1'b0;
        cnt_init  = '0;
        lock_op   = LK_NONE;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    case (cmd)
                        OP_ARRAY:  mode_nxt = RM_ARRAY;
                        OP_IDENT:  mode_nxt = RM_IDENT;
                        OP_STATUS: mode_nxt = RM_STATUS;
                        OP_CLEAR:  err_clr  = 1'b1;
                        OP_PROG: begin
                            state_nxt = ST_PROG_SETUP;
                            mode_nxt  = RM_STATUS;
                        end
                        OP_ERASE: begin
                            state_nxt = ST_ERASE_SETUP;
                            mode_nxt  = RM_STATUS;
                        end
                        OP_LOCK: begin
                            state_nxt = ST_LOCK_SETUP;
                            mode_nxt  = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PROG_SETUP: begin
                if (wr_en) begin
                    if (!vpp_ok) begin
                        err_set[SB_PROG]   = 1'b1;
                        err_set[SB_SUPPLY] = 1'b1;
                        state_nxt          = ST_IDLE;
                    end else if (tgt_locked) begin
                        err_set[SB_PROG]   = 1'b1;
                        err_set[SB_LOCKED] = 1'b1;
                        state_nxt          = ST_IDLE;
                    end else begin
                        cnt_load  = 1'b1;
                        cnt_init  = PROG_LOAD;
                        state_nxt = ST_PROG_BUSY;
                    end
                end
            end
            ST_ERASE_SETUP: begin
                if (wr_en) begin
                    if (cmd != OP_CONFIRM) begin
                        err_set[SB_ERASE] = 1'b1;
                        err_set[SB_PROG]  = 1'b1;
                        state_nxt         = ST_IDLE;
                    end else if (!vpp_ok) begin
                        err_set[SB_ERASE]  = 1'b1;
                        err_set[SB_SUPPLY] = 1'b1;
                        state_nxt          = ST_IDLE;
                    end else if (tgt_locked) begin
                        err_set[SB_ERASE]  = 1'b1;
                        err_set[SB_LOCKED] = 1'b1;
                        state_nxt          = ST_IDLE;
                    end else begin
                        cnt_load  = 1'b1;
                        cnt_init  = ERASE_LOAD;
                        state_nxt = ST_ERASE_BUSY;
                    end
                end
            end
            ST_LOCK_SETUP: begin
                if (wr_en) begin
                    state_nxt = ST_IDLE;
                    case (cmd)
                        OP_LK_SET:    lock_op = LK_SET;
                        OP_CONFIRM:   lock_op = LK_CLEAR;
                        OP_LK_FREEZE: lock_op = LK_FREEZE;
                        default:      lock_op = LK_NONE;
                    endcase
                end
            end
            ST_PROG_BUSY, ST_ERASE_BUSY: begin
                if (wr_en && cmd == OP_STATUS) mode_nxt = RM_STATUS;
                if (cnt_q == '0) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // registered outputs: read mode, error bits, busy counter, operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode <= RM_ARRAY;
            err_q   <= '0;
            cnt_q   <= '0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            rd_mode <= mode_nxt;
            err_q   <= err_clr ? 8'h00 : (err_q | err_set);
            if (cnt_load)                 cnt_q <= cnt_init;
            else if (busy && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (cnt_load) begin
                op_addr <= addr;
                op_data <= wdata;
            end
        end
    end

    assign status       = {~busy, err_q[6:0]};
    assign prog_commit  = (state == ST_PROG_BUSY)  && (cnt_q == '0);
    assign erase_commit = (state == ST_ERASE_BUSY) && (cnt_q == '0);

    p_busy_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (state == $past(state)));

    p_busy_mode_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && cmd != OP_STATUS) |=> (rd_mode == $past(rd_mode)));

    p_clear_errors_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && cmd == OP_CLEAR)
        |=> (status[6:0] == 7'd0 && rd_mode == $past(rd_mode)));

    p_prog_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && cmd == OP_PROG)
        |=> (state == ST_PROG_SETUP && rd_mode == RM_STATUS));

    p_supply_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG_SETUP && wr_en && !vpp_ok)
        |=> (state == ST_IDLE && status[SB_SUPPLY] && status[SB_PROG]));

endmodule

// File: rtl/nor_lock_bits.sv
module nor_lock_bits
    import nor_emu_pkg::*;
#(
    parameter int BLK_IDX_W = 2,
    localparam int NUM_BLK  = 1 << BLK_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lock_op_e             lock_op,
    input  logic [BLK_IDX_W-1:0] lock_blk,
    output logic [NUM_BLK-1:0]   locked,
    output logic [NUM_BLK-1:0]   frozen
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= '1;
            frozen <= '0;
        end else begin
            for (int b = 0; b < NUM_BLK; b++) begin
                if (lock_blk == BLK_IDX_W'(b)) begin
                    case (lock_op)
                        LK_SET:    locked[b] <= 1'b1;
                        LK_CLEAR:  if (!frozen[b]) locked[b] <= 1'b0;
                        LK_FREEZE: begin
                            locked[b] <= 1'b1;
                            frozen[b] <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk_chk
        p_frozen_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            frozen[b] |-> locked[b]);
        p_frozen_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            frozen[b] |=> frozen[b]);
    end

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int ADDR_W         = 5,
    parameter int DATA_W         = 16,
    parameter int BLK_WORDS_LOG2 = 3,
    localparam int NWORDS        = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_commit,
    input  logic              erase_commit,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) mem[w] <= '1;
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                if (erase_commit &&
                    ((op_addr >> BLK_WORDS_LOG2) == (ADDR_W'(w) >> BLK_WORDS_LOG2)))
                    mem[w] <= '1;
                else if (prog_commit && op_addr == ADDR_W'(w))
                    mem[w] <= mem[w] & op_data;
            end
        end
    end

    assign rd_word = mem[rd_addr];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word_chk
        p_prog_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_commit && op_addr == ADDR_W'(w))
            |=> (mem[w] == $past(mem[w] & op_data)));
        p_erase_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (erase_commit && ((op_addr >> BLK_WORDS_LOG2) == (ADDR_W'(w) >> BLK_WORDS_LOG2)))
            |=> (mem[w] == {DATA_W{1'b1}}));
    end

endmodule

// File: rtl/nor_cmd_emu.sv
module nor_cmd_emu
    import nor_emu_pkg::*;
#(
    parameter int DATA_W                = 16,
    parameter int BLK_WORDS_LOG2        = 3,
    parameter int NUM_BLK_LOG2          = 2,
    parameter int PROG_CYCLES           = 16,
    parameter int ERASE_CYCLES          = 256,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00A5,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h5C3E,
    localparam int ADDR_W               = BLK_WORDS_LOG2 + NUM_BLK_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vpp_ok,
    output logic [DATA_W-1:0] rdata
);

    localparam int NUM_BLK = 1 << NUM_BLK_LOG2;
    localparam logic [BLK_WORDS_LOG2-1:0] OFF_MFR  = BLK_WORDS_LOG2'(0);
    localparam logic [BLK_WORDS_LOG2-1:0] OFF_DEV  = BLK_WORDS_LOG2'(1);
    localparam logic [BLK_WORDS_LOG2-1:0] OFF_LOCK = BLK_WORDS_LOG2'(2);

    rd_mode_e                rd_mode;
    logic [7:0]              status;
    lock_op_e                lock_op;
    logic                    prog_commit, erase_commit;
    logic [ADDR_W-1:0]       op_addr;
    logic [DATA_W-1:0]       op_data;
    logic [NUM_BLK-1:0]      locked, frozen;
    logic [NUM_BLK_LOG2-1:0] addr_blk, op_blk;
    logic [DATA_W-1:0]       rd_word, rd_val;

    assign addr_blk = addr[ADDR_W-1:BLK_WORDS_LOG2];
    assign op_blk   = op_addr[ADDR_W-1:BLK_WORDS_LOG2];

    nor_cmd_ctl #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .vpp_ok       (vpp_ok),
        .tgt_locked   (locked[addr_blk]),
        .rd_mode      (rd_mode),
        .status       (status),
        .lock_op      (lock_op),
        .prog_commit  (prog_commit),
        .erase_commit (erase_commit),
        .op_addr      (op_addr),
        .op_data      (op_data)
    );

    nor_lock_bits #(
        .BLK_IDX_W (NUM_BLK_LOG2)
    ) u_locks (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_op  (lock_op),
        .lock_blk (addr_blk),
        .locked   (locked),
        .frozen   (frozen)
    );

    nor_cell_array #(
        .ADDR_W         (ADDR_W),
        .DATA_W         (DATA_W),
        .BLK_WORDS_LOG2 (BLK_WORDS_LOG2)
    ) u_cells (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_commit  (prog_commit),
        .erase_commit (erase_commit),
        .op_addr      (op_addr),
        .op_data      (op_data),
        .rd_addr      (addr),
        .rd_word      (rd_word)
    );

    // read data selection by mode
    always_comb begin
        rd_val = '0;
        case (rd_mode)
            RM_ARRAY:  rd_val = rd_word;
            RM_STATUS: rd_val = DATA_W'(status);
            RM_IDENT: begin
                case (addr[BLK_WORDS_LOG2-1:0])
                    OFF_MFR:  rd_val = MFR_CODE;
                    OFF_DEV:  rd_val = DEV_CODE;
                    OFF_LOCK: rd_val = DATA_W'({frozen[addr_blk], locked[addr_blk]});
                    default:  rd_val = '0;
                endcase
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    p_prog_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_commit |-> !locked[op_blk]);

    p_erase_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_commit |-> !locked[op_blk]);

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/nor_cmd_emu_tb.sv
module nor_cmd_emu_tb;

    localparam int DW  = 16;
    localparam int BWL = 3;
    localparam int NBL = 2;
    localparam int AW  = BWL + NBL;
    localparam int PC  = 3;
    localparam int EC  = 6;
    localparam logic [DW-1:0] MFR = 16'h00A5;
    localparam logic [DW-1:0] DEV = 16'h5C3E;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en, vpp_ok;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;

    int errs   = 0;
    int checks = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          poll_mode;
    logic          rd_seen;

    always #5 clk = ~clk;

    nor_cmd_emu #(
        .DATA_W         (DW),
        .BLK_WORDS_LOG2 (BWL),
        .NUM_BLK_LOG2   (NBL),
        .PROG_CYCLES    (PC),
        .ERASE_CYCLES   (EC),
        .MFR_CODE       (MFR),
        .DEV_CODE       (DEV)
    ) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .vpp_ok (vpp_ok),
        .rdata  (rdata)
    );

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic wr(input int a, input int d);
        addr  = AW'(a);
        wdata = DW'(d);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
        addr  = AW'(a);
        rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // status poll on consecutive cycles; counts reads with ready low
    task automatic poll(input int exp_cnt, input logic [DW-1:0] exp_final, input string tag);
        int n = 0;
        addr      = '0;
        rd_en     = 1'b1;
        poll_mode = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (rdata[7]) break;
            n++;
        end
        rd_en     = 1'b0;
        poll_mode = 1'b0;
        chk(DW'(n), DW'(exp_cnt), {tag, " busy length"});
        chk(rdata, exp_final, {tag, " final status"});
    endtask

    // monitor: compares each scoreboard read one cycle after its edge
    always @(posedge clk) rd_seen <= rd_en && !poll_mode;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                errs++;
                $display("FAIL R13: actual %h expected no read result", rdata);
            end else begin
                chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R12: actual hung run expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; vpp_ok = 1'b1;
        addr = '0; wdata = '0; poll_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R3 identifier data
        rd(0, 16'hFFFF, "R1 array word after reset");
        rd(13, 16'hFFFF, "R1 array word after reset blk1");
        wr(0, 'h70); rd(0, 16'h0080, "R1 R4 status after reset");
        wr(0, 'h90);
        rd(0, MFR, "R3 manufacturer code");
        rd(1, DEV, "R3 device code");
        rd(2, 16'h0001, "R1 R3 block0 locked at reset");
        rd(10, 16'h0001, "R3 block1 lock status");
        rd(3, 16'h0000, "R3 other offset zero");
        rd(9, DEV, "R3 device code in block1");

        // R10 program to locked block
        wr(5, 'h10); wr(5, 'h1234);
        rd(0, 16'h0092, "R10 program locked status");
        wr(0, 'hFF); rd(5, 16'hFFFF, "R10 R2 array unchanged");

        // R5 clear keeps mode
        wr(0, 'h70); rd(0, 16'h0092, "R4 status errors");
        wr(0, 'h50); rd(0, 16'h0080, "R5 errors cleared mode kept");

        // R6 unlock block0
        wr(0, 'h60); wr(0, 'hD0); wr(0, 'h90);
        rd(2, 16'h0000, "R6 block0 unlocked");
        rd(10, 16'h0001, "R6 block1 still locked");

        // R7 program with AND, R12 busy length
        wr(0, 'h10); wr(5, 'h1234);
        poll(PC, 16'h0080, "R12 R7 program");
        wr(0, 'hFF); rd(5, 16'h1234, "R7 R2 programmed word");
        wr(5, 'h10); wr(5, 'hFF0F);
        poll(PC, 16'h0080, "R12 R7 second program");
        wr(0, 'hFF);
        rd(5, 16'h1204, "R7 program ANDs old data");
        rd(4, 16'hFFFF, "R7 neighbour untouched");

        // R11 supply low on program
        vpp_ok = 1'b0;
        wr(6, 'h10); wr(6, 'h0000);
        rd(0, 16'h0098, "R11 program supply error");
        vpp_ok = 1'b1;
        wr(0, 'hFF); rd(6, 16'hFFFF, "R11 array unchanged");
        wr(0, 'h50);

        // R9 bad erase confirm
        wr(0, 'h20); wr(0, 'h55);
        rd(0, 16'h00B0, "R9 sequence error status");
        wr(0, 'h50); wr(0, 'hFF);
        rd(5, 16'h1204, "R9 nothing erased");

        // R8 erase block0, R12 ignored write during busy
        wr(8, 'h60); wr(8, 'hD0);
        wr(9, 'h10); wr(9, 'h00AA);
        poll(PC, 16'h0080, "R7 program block1");
        wr(3, 'h20); wr(3, 'hD0);
        wr(0, 'hFF);
        poll(EC - 1, 16'h0080, "R12 erase with ignored 0xFF");
        wr(0, 'hFF);
        rd(5, 16'hFFFF, "R8 erased word");
        rd(0, 16'hFFFF, "R8 erased first word");
        rd(7, 16'hFFFF, "R8 erased last word");
        rd(9, 16'h00AA, "R8 other block kept");

        // R6 relock, R10 erase of locked block
        wr(9, 'h60); wr(9, 'h01); wr(0, 'h90);
        rd(10, 16'h0001, "R6 block1 relocked");
        wr(9, 'h20); wr(9, 'hD0);
        rd(0, 16'h00A2, "R10 erase locked status");
        wr(0, 'hFF); rd(9, 16'h00AA, "R10 locked block kept");
        wr(0, 'h50);

        // R6 lock-down and ignored codes
        wr(16, 'h60); wr(16, 'h2F); wr(0, 'h90);
        rd(18, 16'h0003, "R6 lock-down status");
        wr(16, 'h60); wr(16, 'hD0); wr(0, 'h90);
        rd(18, 16'h0003, "R6 unlock ignored when locked down");
        wr(24, 'h60); wr(24, 'h77); wr(0, 'h90);
        rd(26, 16'h0001, "R6 unknown lock code ignored");

        // R11 supply low on erase
        vpp_ok = 1'b0;
        wr(0, 'h20); wr(0, 'hD0);
        rd(0, 16'h00A8, "R11 erase supply error");
        vpp_ok = 1'b1;
        wr(0, 'h50);

        // R13 hold while rd_en low
        wr(0, 'hFF);
        rd(5, 16'hFFFF, "R13 read before hold");
        wr(0, 'h70);
        repeat (2) @(negedge clk);
        chk(rdata, 16'hFFFF, "R13 rdata held without read");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule